// File: doc/BRIEF.md
# Split-Edge Register File

This block is the general-purpose register storage of a pipelined 32-bit RISC core: 32 entries of 32 bits, two independent read ports and one write port. Each read port takes a 5-bit source index and registers the selected entry on the rising clock edge. The write port takes a 5-bit destination index, a data word and an enable. It commits on the falling clock edge, and only when the enable is high.

Storage and read registers use opposite clock edges. A result written back in the first half of a cycle is therefore already in storage when the read ports sample on the following rising edge. The decode stage sees the new value with no bypass multiplexer. Entry 0 is a constant zero. A synchronous, active-low reset clears every entry and both read outputs.

Top module: `split_edge_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, storage entries are cleared (falling edge) and both read outputs are cleared (rising edge); after reset every entry reads 0.
- R2: `rd_data_a` takes the content of entry `rd_addr_a` on each rising edge of `clk` while `rst_n` is high, and it does not change between rising edges, even if `rd_addr_a` changes.
- R3: `rd_data_b` behaves as in R2 for `rd_addr_b`, independently of port A, including when both ports select the same entry.
- R4: When `wr_en` is low at a falling edge, no entry changes.
- R5: When `wr_en` is high at a falling edge, only the entry indexed by `wr_addr` takes `wr_data`; every other entry keeps its value.
- R6: A write to entry N (N not 0) at a falling edge is returned by a read of N at the very next rising edge.
- R7: Entry 0 always reads as 0; a write with `wr_addr` = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; reads on rising edge, writes on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable, sampled on falling edge |
| wr_addr | input | 5 | Destination entry index |
| wr_data | input | 32 | Data to write |
| rd_addr_a | input | 5 | Source index, read port A |
| rd_addr_b | input | 5 | Source index, read port B |
| rd_data_a | output | 32 | Registered read data, port A |
| rd_data_b | output | 32 | Registered read data, port B |

## Verification
A write-back and a read of the same entry can fall in the same clock cycle. The write lands on the falling edge and the read is captured on the next rising edge. The random stimulus steers a read index to the write index in roughly a third of the cycles, and directed cases do the same on both ports at once. The bench model applies each write at the falling edge before it predicts the read. Any case that returns the old value is reported under R6, and writes aimed at entry 0 under R7.

// File: rtl/sefrf_pkg.sv
// Package: shared sizing defaults and types for the split-edge register file.
// Assumes the entry count is a power of two so an index covers it exactly.
package sefrf_pkg;
    parameter int unsigned DEF_DATA_W = 32;
    parameter int unsigned DEF_DEPTH  = 32;
    parameter int unsigned NUM_READ   = 2;

    // Index width for a given entry count.
    function automatic int unsigned idx_width(input int unsigned depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction
endpackage

// File: rtl/sefrf_wb_decoder.sv
// Module: write-back decoder. Turns the destination index and enable into a
// one-hot (or all-zero) select vector. Assumes DEPTH = 2**ADDR_W.
module sefrf_wb_decoder #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [DEPTH-1:0]  wr_sel
);
    // Raise exactly one select line when the enable is high.
    always_comb begin
        wr_sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                wr_sel[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sefrf_bank.sv
// Module: storage bank. Each entry is a falling-edge register with its own
// select line; entry 0 has no storage and is a constant zero.
// Assumes wr_sel carries at most one set bit.
module sefrf_bank #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0]              wr_sel,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DEPTH-1:0][DATA_W-1:0]  entries
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign entries[g] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            // Clear on reset, else take write data when selected (falling edge).
            always_ff @(negedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_sel[g]) begin
                    q <= wr_data;
                end
            end
            assign entries[g] = q;
        end
    end
endmodule

// File: rtl/sefrf_read_port.sv
// Module: one read port. A multiplexer picks an entry by index and a
// rising-edge register holds the result for the whole cycle.
// Assumes DEPTH = 2**ADDR_W so every index is a valid entry.
module sefrf_read_port #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0][DATA_W-1:0]  entries,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data
);
    logic [DATA_W-1:0] mux_out;

    // Select the addressed entry.
    always_comb begin
        mux_out = entries[rd_addr];
    end

    // Capture the selected entry on the rising edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mux_out;
        end
    end
endmodule

// File: rtl/split_edge_regfile.sv
// Module: top of the split-edge register file. Writes land on the falling
// edge, reads are registered on the rising edge, so a same-cycle write and
// read of one entry return the new data without bypass logic.
// Assumes a synchronous active-low reset and a power-of-two depth.
module split_edge_regfile #(
    parameter int unsigned DATA_W = sefrf_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = sefrf_pkg::DEF_DEPTH,
    parameter int unsigned ADDR_W = sefrf_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int unsigned NRD = sefrf_pkg::NUM_READ;

    logic [DEPTH-1:0]              wr_sel;
    logic [DEPTH-1:0][DATA_W-1:0]  entries;
    logic [NRD-1:0][ADDR_W-1:0]    rd_idx;
    logic [NRD-1:0][DATA_W-1:0]    rd_val;

    assign rd_idx[0] = rd_addr_a;
    assign rd_idx[1] = rd_addr_b;
    assign rd_data_a = rd_val[0];
    assign rd_data_b = rd_val[1];

    sefrf_wb_decoder #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    sefrf_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .entries (entries)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        sefrf_read_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .entries (entries),
            .rd_addr (rd_idx[p]),
            .rd_data (rd_val[p])
        );
    end
endmodule

// File: rtl/sefrf_checker.sv
// Module: port-level checker for split_edge_regfile. It shadows the write
// seen at each falling edge and judges the read outputs at rising edges.
module sefrf_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);
    logic              lw_en;
    logic [ADDR_W-1:0] lw_addr;
    logic [DATA_W-1:0] lw_data;

    // Record the write accepted at the latest falling edge.
    always_ff @(negedge clk) begin
        lw_en   <= rst_n && wr_en;
        lw_addr <= wr_addr;
        lw_data <= wr_data;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data_a == '0 && rd_data_b == '0));

    assert_hold_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !lw_en && $stable(rd_addr_a)) |=> $stable(rd_data_a));

    assert_other_entry_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(rd_addr_b) && !(lw_en && lw_addr == rd_addr_b))
        |=> $stable(rd_data_b));

    assert_same_cycle_new_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_en && lw_addr == rd_addr_a && rd_addr_a != '0) |=> rd_data_a == $past(lw_data));

    assert_same_cycle_new_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_en && lw_addr == rd_addr_b && rd_addr_b != '0) |=> rd_data_b == $past(lw_data));

    assert_zero_entry_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |=> rd_data_a == '0);

    assert_zero_entry_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |=> rd_data_b == '0);
endmodule

bind split_edge_regfile sefrf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sefrf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/test_split_edge_regfile.sv
// Bench: drives inputs a quarter period after each rising edge, updates a
// reference model at each falling edge and compares read data a quarter
// period after the next rising edge.
module test_split_edge_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NE = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr_a = '0;
    logic [AW-1:0] rd_addr_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;

    logic [DW-1:0] model [NE];
    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_edge_regfile i_split_edge_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a, input logic rst);
        if (!rst || a == '0) return '0;
        return model[a];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // One cycle: drive, apply write to model at falling edge, check after rising edge.
    task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                        input string ta, input string tb);
        logic [DW-1:0] ea, eb;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
        @(negedge clk);
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) model[i] = '0;
        end else if (we && wa != '0) begin
            model[wa] = wd;
        end
        @(posedge clk);
        ea = expect_read(ra, rst_n);
        eb = expect_read(rb, rst_n);
        #(CLK_PERIOD/4);
        check(ta, rd_data_a, ea);
        check(tb, rd_data_b, eb);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [DW-1:0] held;
        for (int i = 0; i < NE; i++) model[i] = 32'hDEAD_0000 + i;
        void'($urandom(32'h5EED_1234));
        @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset, even with a write requested
        step(1'b1, 5'd3, 32'h1111_1111, 5'd3, 5'd0, "R1", "R1");
        step(1'b0, 5'd0, 32'h0, 5'd3, 5'd7, "R1", "R1");
        rst_n = 1'b1;
        // R1: every entry reads zero after reset
        for (int i = 0; i < NE; i += 2) begin
            step(1'b0, 5'd0, 32'h0, AW'(i), AW'(i + 1), "R1", "R1");
        end
        // R6: same-cycle write and read on both ports
        step(1'b1, 5'd5, 32'hCAFE_F00D, 5'd5, 5'd5, "R6", "R6");
        // R7: write to entry zero is ignored
        step(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R7", "R7");
        // R4: write enable low leaves entry 5 alone
        step(1'b0, 5'd5, 32'h1234_5678, 5'd5, 5'd9, "R4", "R4");
        // R5: write to 9 leaves 5 untouched; R3 port B reads the new 9
        step(1'b1, 5'd9, 32'h0BAD_BEEF, 5'd5, 5'd9, "R5", "R3");
        // R6: all-ones data at the top entry
        step(1'b1, 5'd31, 32'hFFFF_FFFF, 5'd31, 5'd1, "R6", "R5");
        // R2: output holds when the address changes mid-cycle
        held = rd_data_a;
        wr_en = 1'b0;
        rd_addr_a = 5'd9;
        #(CLK_PERIOD/2);
        check("R2", rd_data_a, held);
        @(posedge clk);
        #(CLK_PERIOD/4);
        // Random traffic, biased toward same-entry collisions
        for (int n = 0; n < 3000; n++) begin
            logic we;
            logic [AW-1:0] wa, ra, rb;
            logic [DW-1:0] wd;
            we = ($urandom % 10) < 7;
            wa = AW'($urandom);
            wd = $urandom;
            ra = (($urandom % 3) == 0) ? wa : AW'($urandom);
            rb = (($urandom % 3) == 0) ? wa : AW'($urandom);
            step(we, wa, wd, ra, rb,
                 (we && ra == wa) ? ((wa == '0) ? "R7" : "R6") : "R2",
                 (we && rb == wa) ? ((wa == '0) ? "R7" : "R6") : "R3");
        end
        // R1: reset mid-run clears everything again
        rst_n = 1'b0;
        step(1'b1, 5'd4, 32'h5555_AAAA, 5'd4, 5'd31, "R1", "R1");
        rst_n = 1'b1;
        for (int i = 0; i < NE; i += 2) begin
            step(1'b0, 5'd0, 32'h0, AW'(i + 1), AW'(i), "R1", "R1");
        end
        summary();
    end
endmodule